// File: doc/BRIEF.md
# Encoded Microinstruction Field Decoder

This block is a four-word microprogram store. Its 6-bit control words are packed into minimum-width encoded fields. A step counter addresses the store. Each stored word is split into four fields, and each field drives its own small decoder. Together the decoders expand the word into eight control lines, named a to h.

Each field groups control lines that no microinstruction ever asserts together. Because of this, one code per field is enough to select any member. The all-zero code of each field selects nothing.

On every cycle where `step_i` is high, three things happen at the clock edge:
- the word at the current address is decoded;
- the decoded lines are captured into the output register;
- the address advances, wrapping from the last word back to the first.

When `step_i` is low, the outputs and the address hold.

Top module: `ucode_field_decoder`

## Requirements
- R1: While `rst_ni` is low and right after it is released, `ctrl_o` is 8'h00 and `index_o` is 0.
- R2: A clock edge with `step_i` high advances `index_o` by one. From index 3 it wraps to 0.
- R3: A clock edge with `step_i` low leaves both `index_o` and `ctrl_o` unchanged.
- R4: After a clock edge with `step_i` high, `ctrl_o` shows the decoded word at the index that `index_o` showed before that edge. The value appears in the same cycle as the new index.
- R5: The control word layout is as follows:
  - bit 0 is the field {a}, where 1 asserts a;
  - bit 1 is the field {c}, where 1 asserts c;
  - bits 3:2 select b/d/e with 01=b, 10=d, 11=e;
  - bits 5:4 select f/g/h with 01=f, 10=g, 11=h;
  - a code of 0 in any field asserts nothing.
- R6: `ctrl_o` bit k carries control line k in the order a=0, b=1, c=2, d=3, e=4, f=5, g=6, h=7.
- R7: The words at indices 0, 1, 2 and 3 assert exactly {a,b,c,g}, {a,c,e,h}, {a,d,f} and {b,c,f}. In `ctrl_o` these are 8'h47, 8'h95, 8'h29 and 8'h26.
- R8: At most one line of {b,d,e} is high at any time, and at most one line of {f,g,h} is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Issue the current word and advance the address |
| index_o | output | 2 | Address of the word the next step will issue |
| ctrl_o | output | 8 | Registered decoded control lines a..h |

## Verification
The bench builds the block with its default store of four words and the fixed field table. This means three full laps of steps cover every word and every wrap from index 3 back to 0. Expected lines come from an unencoded reference table written as sets of line numbers, so the field packing is never copied. Idle gaps of several cycles between steps, and a reset in the middle of a lap, exercise the hold and restart behaviour.

// File: rtl/ucf_pkg.sv
package ucf_pkg;
  localparam int NUM_WORDS  = 4;
  localparam int ADDR_W     = $clog2(NUM_WORDS);
  localparam int NUM_FIELDS = 4;
  localparam int WORD_W     = 6;
  localparam int NUM_CTRL   = 8;
  // field widths, word bit offsets, offsets into decoded vector (order a,c,b,d,e,f,g,h)
  localparam int FIELD_W   [NUM_FIELDS] = '{1, 1, 2, 2};
  localparam int FIELD_LSB [NUM_FIELDS] = '{0, 1, 2, 4};
  localparam int DEC_OFS   [NUM_FIELDS] = '{0, 1, 2, 5};

  typedef logic [WORD_W-1:0]   word_t;
  typedef logic [NUM_CTRL-1:0] ctrl_t;
endpackage

// File: rtl/ucode_step_ctr.sv
module ucode_step_ctr #(
  parameter int NWORDS = 4,
  localparam int AW    = $clog2(NWORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic [AW-1:0] idx_o
);
  localparam logic [AW-1:0] LAST = AW'(NWORDS - 1);

  logic [AW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (step_i) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  assign idx_o = idx_q;

  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && idx_q == LAST) |=> (idx_q == '0));
  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && idx_q != LAST) |=> (idx_q == $past(idx_q) + 1'b1));
  a_r3_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(idx_q));
endmodule

// File: rtl/ucode_rom.sv
module ucode_rom
  import ucf_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output word_t             word_o
);
  // {fgh[1:0], bde[1:0], c, a}
  always_comb begin
    unique case (addr_i)
      2'd0:    word_o = 6'b10_01_1_1; // a b c g
      2'd1:    word_o = 6'b11_11_1_1; // a c e h
      2'd2:    word_o = 6'b01_10_0_1; // a d f
      default: word_o = 6'b01_01_1_0; // b c f
    endcase
  end
endmodule

// File: rtl/field_dec.sv
module field_dec #(
  parameter int W     = 2,
  localparam int NSEL = (1 << W) - 1
) (
  input  logic [W-1:0]    code_i,
  output logic [NSEL-1:0] sel_o
);
  for (genvar i = 1; i <= NSEL; i++) begin : g_sel
    assign sel_o[i-1] = (code_i == W'(i));
  end

  always_comb a_r8_field_onehot0: assert ($onehot0(sel_o));
endmodule

// File: rtl/ucode_field_decoder.sv
module ucode_field_decoder
  import ucf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [ADDR_W-1:0] index_o,
  output logic [NUM_CTRL-1:0] ctrl_o
);
  logic [ADDR_W-1:0] idx;
  word_t             word;
  ctrl_t             dec_flat; // order a,c,b,d,e,f,g,h
  ctrl_t             ctrl_d, ctrl_q;

  ucode_step_ctr #(.NWORDS(NUM_WORDS)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(step_i),
    .idx_o (idx)
  );

  ucode_rom u_rom (
    .addr_i(idx),
    .word_o(word)
  );

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    localparam int FW = FIELD_W[f];
    localparam int NS = (1 << FW) - 1;
    logic [NS-1:0] sel;
    field_dec #(.W(FW)) u_dec (
      .code_i(word[FIELD_LSB[f] +: FW]),
      .sel_o (sel)
    );
    assign dec_flat[DEC_OFS[f] +: NS] = sel;
  end

  // reorder to a..h
  assign ctrl_d = {dec_flat[7:3], dec_flat[1], dec_flat[2], dec_flat[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctrl_q <= '0;
    else if (step_i) ctrl_q <= ctrl_d;
  end

  assign index_o = idx;
  assign ctrl_o  = ctrl_q;

  a_r3_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(ctrl_q));
  a_r8_bde_onehot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_q[1], ctrl_q[3], ctrl_q[4]}));
  a_r8_fgh_onehot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ctrl_q[7:5]));
  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (ctrl_q == '0 && idx == '0));
endmodule

// File: tb/ucode_field_decoder_test.sv
module ucode_field_decoder_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       step_i = 1'b0;
  logic [1:0] index_o;
  logic [7:0] ctrl_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  ucode_field_decoder uut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .step_i (step_i),
    .index_o(index_o),
    .ctrl_o (ctrl_o)
  );

  // unencoded reference: line numbers a=0..h=7
  function automatic logic [7:0] ref_word(int idx);
    logic [7:0] m = '0;
    case (idx)
      0: begin m[0] = 1; m[1] = 1; m[2] = 1; m[6] = 1; end
      1: begin m[0] = 1; m[2] = 1; m[4] = 1; m[7] = 1; end
      2: begin m[0] = 1; m[3] = 1; m[5] = 1; end
      default: begin m[1] = 1; m[2] = 1; m[5] = 1; end
    endcase
    return m;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(bit s);
    @(negedge clk);
    step_i = s;
    @(negedge clk);
    step_i = 1'b0;
  endtask

  initial begin
    int exp_idx = 0;
    logic [7:0] exp_ctrl = '0;
    repeat (3) @(negedge clk);
    check("R1 ctrl in reset", ctrl_o, 8'h00);
    check("R1 index in reset", index_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 ctrl after reset", ctrl_o, 8'h00);
    check("R1 index after reset", index_o, 0);

    for (int lap = 0; lap < 3; lap++) begin
      for (int k = 0; k < 4; k++) begin
        exp_ctrl = ref_word(exp_idx);
        exp_idx  = (exp_idx + 1) % 4;
        tick(1'b1);
        check("R4 R7 R5 R6 ctrl after step", ctrl_o, exp_ctrl);
        check("R2 index after step", index_o, exp_idx);
        check("R8 bde at most one", $countones({ctrl_o[1], ctrl_o[3], ctrl_o[4]}) <= 1, 1);
        check("R8 fgh at most one", $countones(ctrl_o[7:5]) <= 1, 1);
        for (int g = 0; g < lap; g++) begin
          tick(1'b0);
          check("R3 ctrl hold", ctrl_o, exp_ctrl);
          check("R3 index hold", index_o, exp_idx);
        end
      end
    end

    // back-to-back steps
    @(negedge clk);
    step_i = 1'b1;
    for (int k = 0; k < 5; k++) begin
      exp_ctrl = ref_word(exp_idx);
      exp_idx  = (exp_idx + 1) % 4;
      @(negedge clk);
      check("R4 R7 back-to-back ctrl", ctrl_o, exp_ctrl);
      check("R2 back-to-back index", index_o, exp_idx);
    end
    step_i = 1'b0;

    // reset mid-lap
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1 ctrl mid reset", ctrl_o, 8'h00);
    check("R1 index mid reset", index_o, 0);
    rst_ni = 1'b1;
    tick(1'b1);
    check("R4 R7 first word after reset", ctrl_o, ref_word(0));
    check("R2 index after reset step", index_o, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule